// File: doc/BRIEF.md
# Debug Sub-Module Selector

This block sits at the front of a serial debug port. It is clocked by the test clock and watches the TAP state indicators for the data-register path. While the debug instruction is loaded in the instruction register, every data-register scan passes through it. The block tracks the bits of each scan. At the end of a scan it decides whether the scan was a selection frame for the selector itself or traffic for the sub-module that is already active.

A selection frame is an identifier of `ID_W` bits, sent least-significant bit first, followed by one flag bit. When the last bit shifted before Update-DR is 1, the identifier carried in the bits just before it becomes the active sub-module. When that last bit is 0, the scan belongs to the active sub-module and the selection stays as it is. The block drives one enable per sub-module. It also passes the serial output of the active sub-module to the port output while Shift-DR is asserted. Default identifiers are 0 for the system-bus access unit, 1 for the processor-control unit and 2 for a third unit. Identifier 3 is not populated in the default build.

The frame tracker is a three-state machine. `FR_IDLE` means no scan is open. `FR_FILL` means a scan is open but fewer than `ID_W+1` bits have arrived. `FR_FULL` means at least `ID_W+1` bits have arrived. The transitions are as follows. Capture-DR goes from any state to `FR_FILL`. A shift in `FR_FILL` stays in `FR_FILL` until the `ID_W+1`-th bit and moves to `FR_FULL` on that bit. A shift in `FR_FULL` stays in `FR_FULL`. Update-DR goes from any state to `FR_IDLE`. Dropping the debug instruction goes from any state to `FR_IDLE`. Test-Logic-Reset goes to `FR_IDLE` and clears the selection.

Top module: `dbg_module_select`

## Requirements
- R1: While `tap_reset` is high at a clock edge, the selection is cleared: afterwards `active_valid` is 0, `active_id` is 0, `mod_en` is all zero and `tdo` is 0.
- R2: A Capture-DR, then at least `ID_W+1` Shift-DR bits, then Update-DR selects a module when the last bit shifted is 1. The identifier is taken from the `ID_W` bits shifted just before that last bit, the earliest of them being the least significant. `active_id` and `active_valid` take the new value on the Update-DR edge.
- R3: A complete frame whose last shifted bit is 0 leaves `active_id` and `active_valid` unchanged, whatever its length.
- R4: An Update-DR leaves the selection unchanged in two cases: when fewer than `ID_W+1` bits were shifted since the last Capture-DR, or when no Capture-DR opened the scan.
- R5: In a frame longer than `ID_W+1` bits, only the final `ID_W+1` bits decide the outcome.
- R6: Selecting an identifier of `NUM_MOD` or above (3 by default) leaves no module active: `active_valid` becomes 0 and `active_id` becomes 0.
- R7: `mod_en` is one-hot at bit `active_id` when `active_valid` and `dbg_ir_sel` are both 1, and all zero otherwise.
- R8: `tdo` equals `sub_tdo[active_id]` in the same cycle while `shift_dr`, `dbg_ir_sel` and `active_valid` are all 1, and is 0 otherwise.
- R9: With `dbg_ir_sel` low, capture, shift and update are ignored. Dropping `dbg_ir_sel` during a scan discards the bits already shifted, so the following update changes nothing.
- R10: The selection is kept while `dbg_ir_sel` is low. It routes again as soon as `dbg_ir_sel` returns, with no new selection frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tap_reset | input | 1 | High while the TAP is in Test-Logic-Reset (synchronous) |
| dbg_ir_sel | input | 1 | Debug instruction currently loaded |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| sub_tdo | input | NUM_MOD | Serial outputs of the sub-modules |
| active_id | output | ID_W | Registered identifier of the active sub-module |
| active_valid | output | 1 | A populated sub-module is selected |
| mod_en | output | NUM_MOD | Per-sub-module enable |
| tdo | output | 1 | Serial data out, routed from the active sub-module |

## Verification
The bench goes after frames that are one bit short. A selector that does not count bits since capture would then select from stale shift-register contents. It also sends long command frames, both ending in 0 and ending in 1. A design that decoded the first bits instead of the last ones would pick the wrong module or change selection on ordinary traffic. Selection of the unpopulated identifier is checked: a design without a range check would raise an enable that drives nothing. A scan cut short by the debug instruction dropping mid-frame is also checked: a tracker that kept its bits would wrongly act on the later update.

// File: rtl/dbgsel_pkg.sv
package dbgsel_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_FILL = 2'd1,
        FR_FULL = 2'd2
    } frame_st_e;

endpackage

// File: rtl/dbgsel_frame_fsm.sv
module dbgsel_frame_fsm
    import dbgsel_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic            tck,
    input  logic            tap_reset,
    input  logic            dbg_ir_sel,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            tdi,
    output logic            sel_strobe,
    output logic [ID_W-1:0] sel_id,
    output logic            frame_full
);
    localparam int FRAME_LEN = ID_W + 1;
    localparam int CNT_W     = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);

    frame_st_e            state_q, state_d;
    logic [FRAME_LEN-1:0] sr_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 do_cap, do_shift, do_upd;

    // one action per edge, capture has precedence over shift over update
    always_comb begin
        do_cap   = dbg_ir_sel && capture_dr;
        do_shift = dbg_ir_sel && !capture_dr && shift_dr;
        do_upd   = dbg_ir_sel && !capture_dr && !shift_dr && update_dr;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!dbg_ir_sel) begin
            state_d = FR_IDLE;
        end else if (do_cap) begin
            state_d = FR_FILL;
        end else if (do_upd) begin
            state_d = FR_IDLE;
        end else if (do_shift) begin
            unique case (state_q)
                FR_IDLE: state_d = FR_IDLE;
                FR_FILL: state_d = (cnt_q == LAST_CNT) ? FR_FULL : FR_FILL;
                FR_FULL: state_d = FR_FULL;
                default: state_d = FR_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge tck) begin
        if (tap_reset) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // frame datapath: shift register and bit counter
    always_ff @(posedge tck) begin
        if (tap_reset) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (do_cap) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (do_shift && state_q != FR_IDLE) begin
            sr_q <= {tdi, sr_q[FRAME_LEN-1:1]};
            if (state_q == FR_FILL && cnt_q != LAST_CNT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        frame_full = (state_q == FR_FULL);
        sel_id     = sr_q[ID_W-1:0];
        sel_strobe = do_upd && frame_full && sr_q[FRAME_LEN-1];
    end

endmodule

// File: rtl/dbgsel_select_reg.sv
module dbgsel_select_reg #(
    parameter int NUM_MOD = 3,
    parameter int ID_W    = 2
) (
    input  logic            tck,
    input  logic            tap_reset,
    input  logic            sel_strobe,
    input  logic [ID_W-1:0] sel_id,
    output logic [ID_W-1:0] active_id,
    output logic            active_valid
);
    localparam logic [ID_W:0] POP_LIMIT = (ID_W+1)'(NUM_MOD);

    logic populated;

    always_comb begin
        populated = ({1'b0, sel_id} < POP_LIMIT);
    end

    always_ff @(posedge tck) begin
        if (tap_reset) begin
            active_id    <= '0;
            active_valid <= 1'b0;
        end else if (sel_strobe) begin
            active_id    <= populated ? sel_id : '0;
            active_valid <= populated;
        end
    end

endmodule

// File: rtl/dbgsel_route.sv
module dbgsel_route #(
    parameter int NUM_MOD = 3,
    parameter int ID_W    = 2
) (
    input  logic               dbg_ir_sel,
    input  logic               shift_dr,
    input  logic [ID_W-1:0]    active_id,
    input  logic               active_valid,
    input  logic [NUM_MOD-1:0] sub_tdo,
    output logic [NUM_MOD-1:0] mod_en,
    output logic               tdo
);
    localparam int SLOTS = 1 << ID_W;

    logic             route_on;
    logic [SLOTS-1:0] tdo_slots;

    always_comb begin
        route_on  = dbg_ir_sel && active_valid;
        tdo_slots = SLOTS'(sub_tdo);
        tdo       = route_on && shift_dr && tdo_slots[active_id];
    end

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_en
        assign mod_en[g] = route_on && (active_id == ID_W'(g));
    end

endmodule

// File: rtl/dbg_module_select.sv
module dbg_module_select #(
    parameter int NUM_MOD = 3,
    parameter int ID_W    = 2
) (
    input  logic               tck,
    input  logic               tap_reset,
    input  logic               dbg_ir_sel,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    input  logic [NUM_MOD-1:0] sub_tdo,
    output logic [ID_W-1:0]    active_id,
    output logic               active_valid,
    output logic [NUM_MOD-1:0] mod_en,
    output logic               tdo
);
    logic            sel_strobe;
    logic [ID_W-1:0] sel_id;
    logic            frame_full;

    dbgsel_frame_fsm #(.ID_W(ID_W)) u_frame (
        .tck        (tck),
        .tap_reset  (tap_reset),
        .dbg_ir_sel (dbg_ir_sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .sel_strobe (sel_strobe),
        .sel_id     (sel_id),
        .frame_full (frame_full)
    );

    dbgsel_select_reg #(.NUM_MOD(NUM_MOD), .ID_W(ID_W)) u_sel (
        .tck          (tck),
        .tap_reset    (tap_reset),
        .sel_strobe   (sel_strobe),
        .sel_id       (sel_id),
        .active_id    (active_id),
        .active_valid (active_valid)
    );

    dbgsel_route #(.NUM_MOD(NUM_MOD), .ID_W(ID_W)) u_route (
        .dbg_ir_sel   (dbg_ir_sel),
        .shift_dr     (shift_dr),
        .active_id    (active_id),
        .active_valid (active_valid),
        .sub_tdo      (sub_tdo),
        .mod_en       (mod_en),
        .tdo          (tdo)
    );

endmodule

// File: rtl/dbg_module_select_chk.sv
module dbg_module_select_chk #(
    parameter int NUM_MOD = 3,
    parameter int ID_W    = 2
) (
    input logic               tck,
    input logic               tap_reset,
    input logic               dbg_ir_sel,
    input logic               capture_dr,
    input logic               shift_dr,
    input logic               update_dr,
    input logic [ID_W-1:0]    active_id,
    input logic               active_valid,
    input logic [NUM_MOD-1:0] mod_en,
    input logic               tdo,
    input logic               frame_full
);
    // R1: reset clears the selection
    a_r1_reset_clears: assert property (@(posedge tck)
        tap_reset |=> (!active_valid && active_id == '0));

    // R4: update on a short frame leaves the selection alone
    a_r4_short_frame_hold: assert property (@(posedge tck) disable iff (tap_reset)
        (dbg_ir_sel && update_dr && !capture_dr && !shift_dr && !frame_full)
        |=> ($stable(active_id) && $stable(active_valid)));

    // R9: nothing changes while the debug instruction is absent
    a_r9_ir_off_hold: assert property (@(posedge tck) disable iff (tap_reset)
        !dbg_ir_sel |=> ($stable(active_id) && $stable(active_valid)));

    // R3, R4: selection only moves at an update
    a_r3_only_at_update: assert property (@(posedge tck) disable iff (tap_reset)
        !update_dr |=> ($stable(active_id) && $stable(active_valid)));

    // R7: at most one enable, and only when routing is on
    a_r7_en_onehot: assert property (@(posedge tck) disable iff (tap_reset)
        $onehot0(mod_en));
    a_r7_en_gated: assert property (@(posedge tck) disable iff (tap_reset)
        (!dbg_ir_sel || !active_valid) |-> (mod_en == '0));

    // R8: serial output idle outside Shift-DR
    a_r8_tdo_idle: assert property (@(posedge tck) disable iff (tap_reset)
        !shift_dr |-> !tdo);

    // R6: a valid selection never names an unpopulated slot
    a_r6_id_in_range: assert property (@(posedge tck) disable iff (tap_reset)
        active_valid |-> ({1'b0, active_id} < (ID_W+1)'(NUM_MOD)));
endmodule

bind dbg_module_select dbg_module_select_chk #(.NUM_MOD(NUM_MOD), .ID_W(ID_W)) u_chk (
    .tck          (tck),
    .tap_reset    (tap_reset),
    .dbg_ir_sel   (dbg_ir_sel),
    .capture_dr   (capture_dr),
    .shift_dr     (shift_dr),
    .update_dr    (update_dr),
    .active_id    (active_id),
    .active_valid (active_valid),
    .mod_en       (mod_en),
    .tdo          (tdo),
    .frame_full   (frame_full)
);

// File: tb/sim_dbg_module_select.sv
`timescale 1ns/1ps
module sim_dbg_module_select;
    localparam int NUM_MOD = 3;
    localparam int ID_W    = 2;

    logic               tck = 1'b0;
    logic               tap_reset = 1'b1;
    logic               dbg_ir_sel = 1'b0;
    logic               capture_dr = 1'b0;
    logic               shift_dr = 1'b0;
    logic               update_dr = 1'b0;
    logic               tdi = 1'b0;
    logic [NUM_MOD-1:0] sub_tdo = '0;
    logic [ID_W-1:0]    active_id;
    logic               active_valid;
    logic [NUM_MOD-1:0] mod_en;
    logic               tdo;

    int    checks = 0;
    int    failures = 0;
    int    cyc_no = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model state
    bit q[$];
    bit open_f = 0;
    int m_id = 0;
    bit m_valid = 0;

    always #2.5 tck = ~tck;

    dbg_module_select #(.NUM_MOD(NUM_MOD), .ID_W(ID_W)) u0 (
        .tck(tck), .tap_reset(tap_reset), .dbg_ir_sel(dbg_ir_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .sub_tdo(sub_tdo), .active_id(active_id),
        .active_valid(active_valid), .mod_en(mod_en), .tdo(tdo)
    );

    // behavioural reference, one step per rising edge
    always @(posedge tck) begin
        if (tap_reset) begin
            q.delete(); open_f = 0; m_id = 0; m_valid = 0;
        end else if (!dbg_ir_sel) begin
            q.delete(); open_f = 0;
        end else if (capture_dr) begin
            q.delete(); open_f = 1;
        end else if (shift_dr) begin
            if (open_f) q.push_back(tdi);
        end else if (update_dr) begin
            if (open_f && q.size() >= ID_W + 1 && q[q.size()-1]) begin
                int nid;
                nid = 0;
                for (int b = 0; b < ID_W; b++)
                    nid = nid | (int'(q[q.size()-1-ID_W+b]) << b);
                if (nid < NUM_MOD) begin m_id = nid; m_valid = 1; end
                else begin m_id = 0; m_valid = 0; end
            end
            q.delete(); open_f = 0;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", cur_req, what, cyc_no, act, exp);
        end
    endtask

    task automatic compare();
        int exp_en;
        int exp_tdo;
        exp_en  = (m_valid && dbg_ir_sel) ? (1 << m_id) : 0;
        exp_tdo = (m_valid && dbg_ir_sel && shift_dr) ? int'(sub_tdo[m_id]) : 0;
        chk(active_valid == m_valid, "active_valid", int'(active_valid), int'(m_valid));
        chk(int'(active_id) == m_id, "active_id", int'(active_id), m_id);
        chk(int'(mod_en) == exp_en, "mod_en (R7)", int'(mod_en), exp_en);
        chk(int'(tdo) == exp_tdo, "tdo (R8)", int'(tdo), exp_tdo);
    endtask

    task automatic cyc(input bit ir, input bit cap, input bit sh, input bit upd, input bit d);
        @(negedge tck);
        cyc_no++;
        dbg_ir_sel = ir; capture_dr = cap; shift_dr = sh; update_dr = upd; tdi = d;
        sub_tdo = NUM_MOD'((cyc_no * 5) ^ (cyc_no >> 2));
        #1 compare();
    endtask

    task automatic frame(input bit ir, input int n, input logic [63:0] bits, input bit with_upd);
        cyc(ir, 1, 0, 0, 0);
        for (int i = 0; i < n; i++) cyc(ir, 0, 1, 0, bits[i]);
        if (with_upd) cyc(ir, 0, 0, 1, 0);
        cyc(ir, 0, 0, 0, 0);
    endtask

    task automatic expect_sel(input string tag, input bit v, input int id);
        cur_req = tag;
        chk(active_valid == v, "directed valid", int'(active_valid), int'(v));
        chk(int'(active_id) == id, "directed id", int'(active_id), id);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) cyc(1, 0, 0, 0, 0);
        tap_reset = 1'b0;
        cyc(1, 0, 0, 0, 0);
        expect_sel("R1", 0, 0);

        cur_req = "R2";                        // id 1: bits 1,0 then flag 1
        frame(1, 3, 64'b101, 1);
        expect_sel("R2", 1, 1);

        cur_req = "R8";
        frame(1, 24, 64'h00A5_3C, 0);
        cyc(1, 0, 0, 1, 0);

        cur_req = "R3";
        frame(1, 20, 64'h0_7FFF, 1);           // bit 19 is 0
        expect_sel("R3", 1, 1);

        cur_req = "R4";
        frame(1, 2, 64'b10, 1);                // two bits only
        expect_sel("R4", 1, 1);
        cyc(1, 0, 1, 0, 1); cyc(1, 0, 1, 0, 0); cyc(1, 0, 1, 0, 1);
        cyc(1, 0, 0, 1, 0);                    // update without capture
        cyc(1, 0, 0, 0, 0);
        expect_sel("R4", 1, 1);

        cur_req = "R5";                        // last three bits 0,1,1 -> id 2
        frame(1, 10, 64'b11_0010_1101, 1);
        expect_sel("R5", 1, 2);

        cur_req = "R6";
        frame(1, 3, 64'b111, 1);               // id 3 unpopulated
        expect_sel("R6", 0, 0);
        frame(1, 3, 64'b100, 1);               // id 0
        expect_sel("R6", 1, 0);

        cur_req = "R9";
        frame(0, 3, 64'b110, 1);               // ir low: ignored
        expect_sel("R9", 1, 0);
        cyc(1, 1, 0, 0, 0); cyc(1, 0, 1, 0, 0); cyc(1, 0, 1, 0, 1);
        cyc(0, 0, 0, 0, 0);                    // interrupt the scan
        cyc(1, 0, 1, 0, 1); cyc(1, 0, 0, 1, 0); cyc(1, 0, 0, 0, 0);
        expect_sel("R9", 1, 0);

        cur_req = "R10";
        frame(1, 3, 64'b110, 1);               // id 2
        repeat (4) cyc(0, 0, 1, 0, 1);
        expect_sel("R10", 1, 2);
        repeat (4) cyc(1, 0, 1, 0, 0);

        cur_req = "R7";
        for (int k = 0; k < 400; k++) begin
            int r;
            r = int'($urandom_range(0, 9));
            cyc(r != 0, r == 1 || r == 2, r >= 3 && r <= 7, r == 8, 1'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule